// File: doc/BRIEF.md
# Register Access Workaround Sequencer

This block sits between a host-side register request port and a device's internal register bus. The host hands over one request at a time: read or write, a byte offset, 64-bit write data and a flag that says whether the device is the affected revision. When the flag is set and the offset falls in the low register window, the block wraps the real access in dummy reads that keep the device out of a lockup. It issues a dummy read before the access, then the real access, then one or two dummy reads after it. Otherwise it issues the real access alone.

Every downstream access is a single request that stays on the bus until the device acknowledges it. The sequencer then moves on to the next step. When the whole sequence has finished, the host sees a one-cycle completion pulse. The pulse carries the read data of the real access only. Data returned by dummy reads is thrown away.

States: `ST_IDLE` (ready for a request), `ST_PRE` (leading dummy read), `ST_MAIN` (the real access), `ST_POST_A` (extra trailing dummy read), `ST_POST_B` (final trailing dummy read), `ST_FINISH` (completion pulse). Transitions:
- `ST_IDLE` goes to `ST_PRE` on an accepted wrapped request, or to `ST_MAIN` on an accepted plain request.
- `ST_PRE` goes to `ST_MAIN` on acknowledge.
- `ST_MAIN` goes on acknowledge to `ST_POST_A` (wrapped, offset 0x100), to `ST_POST_B` (wrapped, any other offset) or to `ST_FINISH` (plain).
- `ST_POST_A` goes to `ST_POST_B` on acknowledge.
- `ST_POST_B` goes to `ST_FINISH` on acknowledge.
- `ST_FINISH` goes to `ST_IDLE` unconditionally.

Top module: `reg_wrap_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and both `bus_valid` and `done` are 0.
- R2: With `rev_a_en` = 0, a request at any offset produces exactly one downstream access, at the request offset.
- R3: With `rev_a_en` = 1, a request is wrapped only if its offset is below 0x45000. Offset 0x44FF8 is wrapped; offset 0x45000 and above gives a single access.
- R4: The leading dummy read goes to offset 0xC0 for targets 0x0 and 0x80, to 0x28 for targets 0x148 and 0x200, and to 0x158 for every other wrapped target.
- R5: After the real access of a wrapped request, a dummy read to 0x38 is issued only when the target is 0x100. A dummy read to 0xB050 is always issued last.
- R6: The downstream order is fixed: leading dummy, real access, optional 0x38 dummy, 0xB050 dummy.
- R7: Every dummy access has `bus_write` = 0 and `bus_wdata` = 0. Only the real access carries the request's write flag and write data.
- R8: `done` is high for exactly one cycle per request. In that cycle `done_rdata` holds the real access's read data for a read and is 0 for a write. Dummy read data never appears there.
- R9: `req_ready` is 1 only in `ST_IDLE`. While a sequence is in progress, `req_valid` and changes to the request fields have no effect.
- R10: Each downstream access keeps `bus_valid`, `bus_offset` and `bus_write` stable until the cycle in which `bus_ack` is 1. The sequence works for any acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | AW (32) | Byte offset of the target register |
| req_wdata | input | DW (64) | Write data for the real access |
| rev_a_en | input | 1 | Affected device revision, enables wrapping |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW (64) | Read data of the real access, valid with done |
| bus_valid | output | 1 | Downstream access requested |
| bus_write | output | 1 | Downstream access is a write |
| bus_offset | output | AW (32) | Downstream byte offset |
| bus_wdata | output | DW (64) | Downstream write data |
| bus_ack | input | 1 | Downstream access complete this cycle |
| bus_rdata | input | DW (64) | Downstream read data, valid with bus_ack |

## Verification
A wrong state or a wrong latched classification shows up at the next downstream access, one cycle after acceptance or after an acknowledge. It appears there as a missing, extra or misplaced offset in the logged access order, or as a dummy that drives write data. A fault in read data capture is only visible on the completion pulse, when `done_rdata` carries a dummy's value or a stale value. A stuck state shows as `req_ready` staying low after the last acknowledge. Each scenario therefore compares the full logged access list, the completion data and the return to idle.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_MAIN   = 3'd2,
        ST_POST_A = 3'd3,
        ST_POST_B = 3'd4,
        ST_FINISH = 3'd5
    } step_e;

    // Window and dummy offsets of the lockup avoidance sequence
    localparam logic [31:0] WIN_LIMIT   = 32'h0004_5000;
    localparam logic [31:0] TGT_LOW0    = 32'h0000_0000;
    localparam logic [31:0] TGT_LOW1    = 32'h0000_0080;
    localparam logic [31:0] TGT_MID0    = 32'h0000_0148;
    localparam logic [31:0] TGT_MID1    = 32'h0000_0200;
    localparam logic [31:0] TGT_EXTRA   = 32'h0000_0100;
    localparam logic [31:0] DUMMY_LOW   = 32'h0000_00C0;
    localparam logic [31:0] DUMMY_MID   = 32'h0000_0028;
    localparam logic [31:0] DUMMY_OTHER = 32'h0000_0158;
    localparam logic [31:0] DUMMY_EXTRA = 32'h0000_0038;
    localparam logic [31:0] DUMMY_LAST  = 32'h0000_B050;

endpackage

// File: rtl/wrap_classify.sv
module wrap_classify
    import wrap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] offset_i,
    input  logic          enable_i,
    output logic          wrap_o,
    output logic          extra_o,
    output logic [AW-1:0] pre_off_o
);

    localparam logic [AW-1:0] LIMIT   = AW'(WIN_LIMIT);
    localparam logic [AW-1:0] LOW0    = AW'(TGT_LOW0);
    localparam logic [AW-1:0] LOW1    = AW'(TGT_LOW1);
    localparam logic [AW-1:0] MID0    = AW'(TGT_MID0);
    localparam logic [AW-1:0] MID1    = AW'(TGT_MID1);
    localparam logic [AW-1:0] EXTRA   = AW'(TGT_EXTRA);

    always_comb begin
        wrap_o  = enable_i && (offset_i < LIMIT);
        extra_o = (offset_i == EXTRA);
        if ((offset_i == LOW0) || (offset_i == LOW1)) begin
            pre_off_o = AW'(DUMMY_LOW);
        end else if ((offset_i == MID0) || (offset_i == MID1)) begin
            pre_off_o = AW'(DUMMY_MID);
        end else begin
            pre_off_o = AW'(DUMMY_OTHER);
        end
    end

endmodule

// File: rtl/wrap_seq_fsm.sv
module wrap_seq_fsm
    import wrap_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wrap_in_i,
    input  logic          wrap_q_i,
    input  logic          extra_q_i,
    input  logic [AW-1:0] pre_off_i,
    input  logic [AW-1:0] main_off_i,
    input  logic          write_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          bus_ack_i,
    output logic          req_ready_o,
    output logic          bus_valid_o,
    output logic          bus_write_o,
    output logic [AW-1:0] bus_offset_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          main_ack_o,
    output logic          done_o
);

    step_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = wrap_in_i ? ST_PRE : ST_MAIN;
                end
            end
            ST_PRE: begin
                if (bus_ack_i) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (bus_ack_i) begin
                    if (!wrap_q_i) begin
                        state_d = ST_FINISH;
                    end else if (extra_q_i) begin
                        state_d = ST_POST_A;
                    end else begin
                        state_d = ST_POST_B;
                    end
                end
            end
            ST_POST_A: begin
                if (bus_ack_i) begin
                    state_d = ST_POST_B;
                end
            end
            ST_POST_B: begin
                if (bus_ack_i) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req_ready_o  = 1'b0;
        bus_valid_o  = 1'b0;
        bus_write_o  = 1'b0;
        bus_offset_o = '0;
        bus_wdata_o  = '0;
        main_ack_o   = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready_o = 1'b1;
            ST_PRE: begin
                bus_valid_o  = 1'b1;
                bus_offset_o = pre_off_i;
            end
            ST_MAIN: begin
                bus_valid_o  = 1'b1;
                bus_offset_o = main_off_i;
                bus_write_o  = write_i;
                bus_wdata_o  = write_i ? wdata_i : '0;
                main_ack_o   = bus_ack_i;
            end
            ST_POST_A: begin
                bus_valid_o  = 1'b1;
                bus_offset_o = AW'(DUMMY_EXTRA);
            end
            ST_POST_B: begin
                bus_valid_o  = 1'b1;
                bus_offset_o = AW'(DUMMY_LAST);
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    // R10
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_ack_i) |=>
            (bus_valid_o && $stable(bus_offset_o) && $stable(bus_write_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o));

    // R9
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (bus_valid_o && !req_ready_o));

    // R6
    final_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST_B && bus_ack_i) |=> done_o);

endmodule

// File: rtl/reg_wrap_seq.sv
module reg_wrap_seq
    import wrap_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_offset,
    input  logic [DW-1:0] req_wdata,
    input  logic          rev_a_en,
    output logic          done,
    output logic [DW-1:0] done_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_offset,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);

    logic          start;
    logic          wrap_now, extra_now;
    logic [AW-1:0] pre_now;
    logic          wrap_q, extra_q, write_q;
    logic [AW-1:0] pre_q, off_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          main_ack;

    assign start = req_valid && req_ready;

    wrap_classify #(.AW(AW)) u_classify (
        .offset_i  (req_offset),
        .enable_i  (rev_a_en),
        .wrap_o    (wrap_now),
        .extra_o   (extra_now),
        .pre_off_o (pre_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q  <= 1'b0;
            extra_q <= 1'b0;
            write_q <= 1'b0;
            pre_q   <= '0;
            off_q   <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wrap_q  <= wrap_now;
            extra_q <= extra_now;
            write_q <= req_write;
            pre_q   <= pre_now;
            off_q   <= req_offset;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (start) begin
            rdata_q <= '0;
        end else if (main_ack && !write_q) begin
            rdata_q <= bus_rdata;
        end
    end

    wrap_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .wrap_in_i    (wrap_now),
        .wrap_q_i     (wrap_q),
        .extra_q_i    (extra_q),
        .pre_off_i    (pre_q),
        .main_off_i   (off_q),
        .write_i      (write_q),
        .wdata_i      (wdata_q),
        .bus_ack_i    (bus_ack),
        .req_ready_o  (req_ready),
        .bus_valid_o  (bus_valid),
        .bus_write_o  (bus_write),
        .bus_offset_o (bus_offset),
        .bus_wdata_o  (bus_wdata),
        .main_ack_o   (main_ack),
        .done_o       (done)
    );

    assign done_rdata = done ? rdata_q : '0;

endmodule

// File: tb/reg_wrap_seq_tb_top.sv
module reg_wrap_seq_tb_top;

    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rev_a_en = 1'b0;
    logic          done;
    logic [DW-1:0] done_rdata;
    logic          bus_valid;
    logic          bus_write;
    logic [AW-1:0] bus_offset;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [AW-1:0] log_off [8];
    logic          log_wr  [8];
    logic [DW-1:0] log_wd  [8];
    int            log_n = 0;
    int            ack_lat = 0;

    always #2 clk = ~clk;

    reg_wrap_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .rev_a_en   (rev_a_en),
        .done       (done),
        .done_rdata (done_rdata),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_offset (bus_offset),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata)
    );

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] off);
        return 64'hD0D0_5A5A_0000_0000 | {32'h0, off};
    endfunction

    // Downstream register model: logs every acknowledged access
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_valid) begin
                if (wait_cnt < ack_lat) begin
                    wait_cnt++;
                end else begin
                    if (log_n < 8) begin
                        log_off[log_n] = bus_offset;
                        log_wr[log_n]  = bus_write;
                        log_wd[log_n]  = bus_wdata;
                    end
                    log_n++;
                    bus_rdata = rd_fn(bus_offset);
                    bus_ack   = 1'b1;
                    wait_cnt  = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        check(bus_valid == 1'b0, "R1", "bus_valid after reset", 64'(bus_valid), 64'd0);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
    endtask

    // One request, full sequence checked against the requirement model
    task automatic run_case(input string req, input bit rev, input logic [AW-1:0] off,
                            input bit wr, input logic [DW-1:0] wd, input int lat,
                            input bit hold_busy);
        logic [AW-1:0] exp_off [4];
        bit            exp_main [4];
        int            exp_n;
        bit            wrap;
        bit            busy_ok;
        bit            seen_done;
        logic [DW-1:0] exp_rd;

        wrap  = rev && (off < 32'h0004_5000);
        exp_n = 0;
        if (wrap) begin
            if (off == 32'h0 || off == 32'h80) exp_off[exp_n] = 32'hC0;
            else if (off == 32'h148 || off == 32'h200) exp_off[exp_n] = 32'h28;
            else exp_off[exp_n] = 32'h158;
            exp_main[exp_n] = 1'b0;
            exp_n++;
        end
        exp_off[exp_n] = off; exp_main[exp_n] = 1'b1; exp_n++;
        if (wrap && off == 32'h100) begin
            exp_off[exp_n] = 32'h38; exp_main[exp_n] = 1'b0; exp_n++;
        end
        if (wrap) begin
            exp_off[exp_n] = 32'hB050; exp_main[exp_n] = 1'b0; exp_n++;
        end
        exp_rd = wr ? '0 : rd_fn(off);

        ack_lat = lat;
        log_n   = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R9", {req, " ready before request"}, 64'(req_ready), 64'd1);
        rev_a_en   = rev;
        req_offset = off;
        req_write  = wr;
        req_wdata  = wd;
        req_valid  = 1'b1;
        @(negedge clk);
        if (hold_busy) begin
            req_offset = 32'h200;
            req_write  = ~wr;
            req_wdata  = 64'hBAD0_BAD0_BAD0_BAD0;
        end else begin
            req_valid = 1'b0;
        end
        busy_ok   = 1'b1;
        seen_done = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                seen_done = 1'b1;
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        check(seen_done, "R8", {req, " done seen"}, 64'(seen_done), 64'd1);
        check(busy_ok, "R9", {req, " ready low while busy"}, 64'(busy_ok), 64'd1);
        check(done_rdata == exp_rd, "R8", {req, " done_rdata"}, done_rdata, exp_rd);
        req_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8", {req, " done one cycle"}, 64'(done), 64'd0);
        check(req_ready == 1'b1, "R9", {req, " back to idle"}, 64'(req_ready), 64'd1);
        @(negedge clk);
        check(bus_valid == 1'b0, "R9", {req, " no re-accept"}, 64'(bus_valid), 64'd0);
        check(log_n == exp_n, req, "access count", 64'(log_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            check(log_off[k] == exp_off[k], "R6", {req, " access offset order"},
                  64'(log_off[k]), 64'(exp_off[k]));
            if (exp_main[k]) begin
                check(log_wr[k] == wr, "R7", {req, " main write flag"}, 64'(log_wr[k]), 64'(wr));
                check(log_wd[k] == (wr ? wd : '0), "R7", {req, " main wdata"},
                      log_wd[k], wr ? wd : 64'h0);
            end else begin
                check(log_wr[k] == 1'b0, "R7", {req, " dummy is read"}, 64'(log_wr[k]), 64'd0);
                check(log_wd[k] == '0, "R7", {req, " dummy wdata zero"}, log_wd[k], 64'd0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R2 pass-through
        run_case("R2", 1'b0, 32'h0000_0000, 1'b0, '0, 0, 1'b0);
        run_case("R2", 1'b0, 32'h0000_0100, 1'b1, 64'h1111_2222_3333_4444, 0, 1'b0);
        // R4 leading dummy selection
        run_case("R4", 1'b1, 32'h0000_0000, 1'b0, '0, 0, 1'b0);
        run_case("R4", 1'b1, 32'h0000_0080, 1'b1, 64'hA5A5_0000_FFFF_0001, 0, 1'b0);
        run_case("R4", 1'b1, 32'h0000_0148, 1'b0, '0, 0, 1'b0);
        run_case("R4", 1'b1, 32'h0000_0200, 1'b1, 64'h0123_4567_89AB_CDEF, 0, 1'b0);
        run_case("R4", 1'b1, 32'h0000_1000, 1'b0, '0, 0, 1'b0);
        // R5 trailing dummies
        run_case("R5", 1'b1, 32'h0000_0100, 1'b0, '0, 0, 1'b0);
        run_case("R5", 1'b1, 32'h0000_0108, 1'b1, 64'hFEED_FACE_0000_0007, 0, 1'b0);
        // R3 window boundary
        run_case("R3", 1'b1, 32'h0004_4FF8, 1'b0, '0, 0, 1'b0);
        run_case("R3", 1'b1, 32'h0004_5000, 1'b0, '0, 0, 1'b0);
        run_case("R3", 1'b1, 32'h0008_0000, 1'b1, 64'h7777_8888_9999_AAAA, 0, 1'b0);
        // R10 slow acknowledge
        run_case("R10", 1'b1, 32'h0000_0100, 1'b1, 64'h5555_6666_7777_8888, 3, 1'b0);
        run_case("R10", 1'b1, 32'h0000_0080, 1'b0, '0, 5, 1'b0);
        // R9 request held and changed while busy
        run_case("R9", 1'b1, 32'h0000_0148, 1'b0, '0, 1, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule